// File: doc/BRIEF.md
# Card Clock Phase Select Register

This block is a single control register for the clocking side of a storage-card host interface. It keeps three 3-bit settings: the receive sample phase, the transmit drive phase and a clock divider. It also keeps a sticky wake-up interrupt flag. Software reaches the register through a simple write-strobe / read-data bus. The three settings go out continuously on their own pins, for use by the phase-shift and clock logic outside this block.

Two shortcut ports change the sample phase without a full read-modify-write. A direct sample write replaces only the sample field. A step pulse advances the sample field by one and wraps from 7 to 0. Both are meant for a tuning sequence that sweeps every phase.

Command words bound for the card pass through the block on a valid/ready stream. The stream adds no storage and no delay. The output valid is the input valid, and the input ready is the output ready, so back-pressure from the consumer reaches the producer in the same cycle. A word is transferred on any cycle in which valid and ready are both high. While the drive phase is nonzero, bit 29 of each passing word is forced to 1, which selects the hold register. While the drive phase is zero, bit 29 is forced to 0, which bypasses the hold register.

Top module: `card_clk_phase_reg`

## Requirements
- R1: After reset, the sample, drive and divider fields are 0, the wake flag is 0, the read data is 0 and the interrupt is low.
- R2: A bus write loads the sample field from bits 2:0, the drive field from bits 18:16 and the divider from bits 26:24. The new values show on the read data, at the same positions, and on the phase outputs after the clock edge.
- R3: Every read-data bit other than 2:0, 11, 18:16 and 26:24 reads 0 whatever value was written to it.
- R4: A wake event pulse sets the flag. The flag reads as bit 11 from the next cycle and stays set until it is cleared.
- R5: A bus write with bit 11 at 1 clears the flag. A bus write with bit 11 at 0 leaves the flag as it was. A wake event in the same cycle as a clear leaves the flag set.
- R6: The interrupt output equals the wake flag ANDed with the enable input.
- R7: A direct sample write replaces bits 2:0 and leaves the drive field, the divider and the flag unchanged.
- R8: A step pulse replaces the sample field with (sample + 1) mod 8, so 7 wraps to 0, and leaves all other bits unchanged.
- R9: When update sources meet in the same cycle, the sample field is taken from the bus write first, then from the direct sample write, then from the step.
- R10: Outgoing command bit 29 is 1 when the drive field is nonzero and 0 when it is zero. The hold-enable output follows the same rule. All other command bits pass through unchanged.
- R11: The command output valid equals the input valid, and the input ready equals the output ready, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| smp_we | input | 1 | Direct sample-field write strobe |
| smp_wval | input | 3 | Direct sample-field value |
| smp_step | input | 1 | Advance the sample field by one |
| wake_evt | input | 1 | Wake event pulse |
| wake_irq_en | input | 1 | Wake interrupt enable |
| wake_irq | output | 1 | Wake interrupt |
| smp_phase | output | 3 | Current sample phase |
| drv_phase | output | 3 | Current drive phase |
| clk_div | output | 3 | Current divider |
| hold_en | output | 1 | Hold register selected |
| cmd_in_valid | input | 1 | Command in valid |
| cmd_in_ready | output | 1 | Command in ready |
| cmd_in_data | input | 32 | Command word in |
| cmd_out_valid | output | 1 | Command out valid |
| cmd_out_ready | input | 1 | Command out ready |
| cmd_out_data | output | 32 | Command word out |

## Verification
The bench builds the block with its default parameters: 3-bit phase fields, a 32-bit register and 32-bit command words. With these values the sample field can run through all eight phases, so random steps reach the 7-to-0 wrap often. Every reserved bit of the 32-bit register is also reachable, so random all-ones writes show that those bits read 0. Random cycles mix bus writes, sample writes, steps and wake events, often several in the same cycle, which brings the update-source priority and the set-against-clear race of the flag within reach.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
  // Field positions decoded by the clocking logic and by software
  localparam int SMP_LSB  = 0;
  localparam int WAKE_BIT = 11;
  localparam int DRV_LSB  = 16;
  localparam int DIV_LSB  = 24;
  // Command-word bit that selects the hold register
  localparam int HOLD_BIT = 29;
endpackage

// File: rtl/ckp_phase_fields.sv
module ckp_phase_fields #(
  parameter int PH_W  = 3,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             smp_we,
  input  logic [PH_W-1:0]  smp_wval,
  input  logic             smp_step,
  output logic [PH_W-1:0]  smp,
  output logic [PH_W-1:0]  drv,
  output logic [PH_W-1:0]  div
);
  import ckp_pkg::*;

  logic [PH_W-1:0] smp_nx;

  // Sample field sources, highest priority first: bus, direct write, step
  always_comb begin
    if (bus_we)        smp_nx = bus_wdata[SMP_LSB +: PH_W];
    else if (smp_we)   smp_nx = smp_wval;
    else if (smp_step) smp_nx = smp + 1'b1;
    else               smp_nx = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= '0;
      drv <= '0;
      div <= '0;
    end else begin
      smp <= smp_nx;
      if (bus_we) begin
        drv <= bus_wdata[DRV_LSB +: PH_W];
        div <= bus_wdata[DIV_LSB +: PH_W];
      end
    end
  end

  // R8: a lone step advances the sample field modulo its width
  a_r8_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_step && !bus_we && !smp_we) |=> smp == (PH_W)'($past(smp) + 1'b1));
  // R7: a direct sample write keeps the drive field and the divider
  a_r7_smp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_we && !bus_we) |=> (drv == $past(drv)) && (div == $past(div)));
  // R9: the bus write wins the sample field
  a_r9_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> smp == $past(bus_wdata[SMP_LSB +: PH_W]));
  // R2: the drive field and the divider change only on a bus write
  a_r2_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(drv) && $stable(div));
endmodule

// File: rtl/ckp_wake_flag.sv
module ckp_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  // A wake event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (wake_evt) flag <= 1'b1;
    else if (clr_req)  flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  // R5: a wake event always leaves the flag set
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> flag);
  // R4: without a clear request the flag is sticky
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
  // R4: the flag rises only after a wake event
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wake_evt));
endmodule

// File: rtl/ckp_cmd_hold.sv
module ckp_cmd_hold #(
  parameter int PH_W  = 3,
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  drv,
  output logic             hold_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CMD_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CMD_W-1:0] out_data
);
  import ckp_pkg::*;

  assign hold_en   = |drv;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  always_comb begin
    out_data           = in_data;
    out_data[HOLD_BIT] = hold_en;
  end

  // R10: the other bits of a command word pass unchanged
  a_r10_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_data ^ in_data) & ~(CMD_W'(1) << HOLD_BIT)) == '0);
  // R10: a zero drive field means the hold bit is clear
  a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == '0) |-> !out_data[HOLD_BIT]);
endmodule

// File: rtl/card_clk_phase_reg.sv
module card_clk_phase_reg #(
  parameter int PH_W  = 3,
  parameter int REG_W = 32,
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             smp_we,
  input  logic [PH_W-1:0]  smp_wval,
  input  logic             smp_step,
  input  logic             wake_evt,
  input  logic             wake_irq_en,
  output logic             wake_irq,
  output logic [PH_W-1:0]  smp_phase,
  output logic [PH_W-1:0]  drv_phase,
  output logic [PH_W-1:0]  clk_div,
  output logic             hold_en,
  input  logic             cmd_in_valid,
  output logic             cmd_in_ready,
  input  logic [CMD_W-1:0] cmd_in_data,
  output logic             cmd_out_valid,
  input  logic             cmd_out_ready,
  output logic [CMD_W-1:0] cmd_out_data
);
  import ckp_pkg::*;

  logic wake_flag;

  ckp_phase_fields #(.PH_W(PH_W), .REG_W(REG_W)) u_fields (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_wdata(bus_wdata),
    .smp_we(smp_we), .smp_wval(smp_wval), .smp_step(smp_step),
    .smp(smp_phase), .drv(drv_phase), .div(clk_div)
  );

  ckp_wake_flag u_wake (
    .clk(clk), .rst_n(rst_n),
    .wake_evt(wake_evt),
    .clr_req(bus_we & bus_wdata[WAKE_BIT]),
    .irq_en(wake_irq_en),
    .flag(wake_flag), .irq(wake_irq)
  );

  ckp_cmd_hold #(.PH_W(PH_W), .CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .drv(drv_phase), .hold_en(hold_en),
    .in_valid(cmd_in_valid), .in_ready(cmd_in_ready), .in_data(cmd_in_data),
    .out_valid(cmd_out_valid), .out_ready(cmd_out_ready), .out_data(cmd_out_data)
  );

  // Read image: defined fields at their positions, every other bit zero
  always_comb begin
    bus_rdata                    = '0;
    bus_rdata[SMP_LSB +: PH_W]   = smp_phase;
    bus_rdata[DRV_LSB +: PH_W]   = drv_phase;
    bus_rdata[DIV_LSB +: PH_W]   = clk_div;
    bus_rdata[WAKE_BIT]          = wake_flag;
  end

  // R6: the interrupt never fires without its enable
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_irq_en);
  // R11: valid and ready pass straight through
  a_r11_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out_valid == cmd_in_valid) && (cmd_in_ready == cmd_out_ready));
endmodule

// File: tb/sim_card_clk_phase_reg.sv
`timescale 1ns/1ps
module sim_card_clk_phase_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_we = 1'b0;
  logic [2:0]  smp_wval = '0;
  logic        smp_step = 1'b0;
  logic        wake_evt = 1'b0;
  logic        wake_irq_en = 1'b0;
  logic        wake_irq;
  logic [2:0]  smp_phase, drv_phase, clk_div;
  logic        hold_en;
  logic        cmd_in_valid = 1'b0;
  logic        cmd_in_ready;
  logic [31:0] cmd_in_data = '0;
  logic        cmd_out_valid;
  logic        cmd_out_ready = 1'b0;
  logic [31:0] cmd_out_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] m = '0;   // expected register image

  always #2.5 clk = ~clk;

  card_clk_phase_reg u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_next(input logic [31:0] cur, input logic we,
      input logic [31:0] wd, input logic swe, input logic [2:0] sv, input logic st,
      input logic wk);
    logic [31:0] n = cur;
    if (we) begin
      n[2:0] = wd[2:0]; n[18:16] = wd[18:16]; n[26:24] = wd[26:24];
    end else if (swe) n[2:0] = sv;
    else if (st) n[2:0] = cur[2:0] + 3'd1;
    if (wk) n[11] = 1'b1;
    else if (we && wd[11]) n[11] = 1'b0;
    return n;
  endfunction

  function automatic logic [31:0] exp_cmd(input logic [31:0] d, input logic [31:0] img);
    logic [31:0] r = d;
    r[29] = (img[18:16] != 3'd0);
    return r;
  endfunction

  // One cycle: drive at the falling edge, check the stream path before the
  // rising edge, check the register image just after it.
  task automatic step(input string tag, input logic we, input logic [31:0] wd,
      input logic swe, input logic [2:0] sv, input logic st, input logic wk,
      input logic en, input logic cv, input logic cr, input logic [31:0] cd);
    logic [31:0] nx;
    @(negedge clk);
    bus_we = we; bus_wdata = wd; smp_we = swe; smp_wval = sv; smp_step = st;
    wake_evt = wk; wake_irq_en = en;
    cmd_in_valid = cv; cmd_out_ready = cr; cmd_in_data = cd;
    #1;
    chk({tag, " R10 cmd"}, cmd_out_data, exp_cmd(cd, m));
    chk({tag, " R10 hold_en"}, {31'd0, hold_en}, {31'd0, m[18:16] != 3'd0});
    chk({tag, " R11 stream"}, {30'd0, cmd_out_valid, cmd_in_ready}, {30'd0, cv, cr});
    nx = exp_next(m, we, wd, swe, sv, st, wk);
    @(posedge clk);
    #1;
    m = nx;
    chk({tag, " R2 rdata"}, bus_rdata, m);
    chk({tag, " R2 pins"}, {23'd0, smp_phase, drv_phase, clk_div},
        {23'd0, m[2:0], m[18:16], m[26:24]});
    chk({tag, " R6 irq"}, {31'd0, wake_irq}, {31'd0, m[11] & en});
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 0, 0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rdata", bus_rdata, 32'h0);
    chk("R1 reset irq", {31'd0, wake_irq}, 32'h0);
    rst_n = 1'b1;

    // R2/R3: all-ones write, reserved bits read zero, bit 11 write clears
    step("R3 all ones", 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1, 1, 32'h0000_0000);
    chk("R3 reserved zero", bus_rdata, 32'h0707_0007);
    // R4: wake event sets flag, sticky across idle cycles
    step("R4 wake", 0, 0, 0, 0, 0, 1, 1, 0, 0, 32'h0);
    idle("R4 sticky");
    chk("R4 flag bit11", {31'd0, bus_rdata[11]}, 32'd1);
    // R5: write 0 to bit 11 leaves the flag; R10 with drive zero clears bit 29
    step("R5 write zero", 1, 32'h0000_0000, 0, 0, 0, 0, 1, 1, 1, 32'hFFFF_FFFF);
    chk("R5 zero no clear", {31'd0, bus_rdata[11]}, 32'd1);
    step("R10 bypass", 0, 0, 0, 0, 0, 0, 1, 1, 1, 32'hFFFF_FFFF);
    chk("R10 bit29 clear", {31'd0, cmd_out_data[29]}, 32'd0);
    // R5: set and clear in the same cycle, flag stays
    step("R5 race", 1, 32'h0000_0800, 0, 0, 0, 1, 1, 0, 0, 32'h0);
    chk("R5 set wins", {31'd0, bus_rdata[11]}, 32'd1);
    // R6: enable low masks the interrupt
    step("R6 masked", 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    chk("R6 irq off", {31'd0, wake_irq}, 32'd0);
    step("R5 clear", 1, 32'h0000_0800, 0, 0, 0, 0, 1, 0, 0, 32'h0);
    chk("R5 cleared", {31'd0, bus_rdata[11]}, 32'd0);
    // R7: direct sample write keeps drive and divider
    step("R7 setup", 1, 32'h0503_0001, 0, 0, 0, 0, 1, 0, 0, 32'h0);
    step("R7 smp write", 0, 0, 1, 3'd6, 0, 0, 1, 1, 1, 32'h0000_1234);
    chk("R7 image", bus_rdata, 32'h0503_0006);
    chk("R10 bit29 set", cmd_out_data, 32'h2000_1234);
    // R8: steps wrap 6 -> 7 -> 0
    step("R8 step a", 0, 0, 0, 0, 1, 0, 1, 0, 0, 32'h0);
    step("R8 step b", 0, 0, 0, 0, 1, 0, 1, 0, 0, 32'h0);
    chk("R8 wrap", bus_rdata, 32'h0503_0000);
    // R9: priority between sources
    step("R9 all", 1, 32'h0000_0002, 1, 3'd5, 1, 0, 1, 0, 0, 32'h0);
    chk("R9 bus wins", {29'd0, smp_phase}, 32'd2);
    step("R9 smp over step", 0, 0, 1, 3'd4, 1, 0, 1, 0, 0, 32'h0);
    chk("R9 smp wins", {29'd0, smp_phase}, 32'd4);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      step("R2 R8 random",
           ($urandom_range(0, 3) == 0), wd,
           ($urandom_range(0, 3) == 0), 3'($urandom),
           ($urandom_range(0, 1) == 0),
           ($urandom_range(0, 5) == 0),
           1'($urandom), 1'($urandom), 1'($urandom), $urandom);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule